// File: doc/BRIEF.md
# Active-Zero-State Vector Sequencer

This block drives the three leg gate bits of a two-level three-phase inverter over one switching period. It never uses the two rail states (all legs low, all legs high). The zero-voltage share of the period is built from two opposing active states instead. Each sector has one such pair, and the two states of the pair cancel each other in the average.

The caller supplies a sector number and three dwell counts in clock cycles: one for each of the two adjacent active states and one for the effective-zero time. The block samples these at every period boundary. It then walks a mirrored eight-segment pattern and reports the gate bits and the index of the current segment. Computing the dwell counts and inserting dead time are left to other blocks.

Because every emitted state has exactly one or two legs high, the common-mode voltage moves over one third of the DC link only.

Top module: `azs_sequencer`

## Requirements
- R1: `gate_o` never equals 000 or 111. Every value has one or two bits set, so the common-mode swing is one third of the DC link.
- R2: `gate_o` bit 2 is leg A, bit 1 is leg B and bit 0 is leg C. Each sector uses four states, listed as (first zero substitute, first active, second active, second zero substitute):
  - sector 1: 101, 100, 110, 010
  - sector 2: 011, 010, 110, 100
  - sector 3: 110, 010, 011, 001
  - sector 4: 101, 001, 011, 010
  - sector 5: 011, 001, 101, 100
  - sector 6: 110, 100, 101, 001
- R3: Within a period, `seg_o` only counts upward, from 0 to 7. The segments emit, in order: first zero substitute (0), first active (1), second active (2), second zero substitute (3 and 4), second active (5), first active (6), first zero substitute (7).
- R4: The first active dwell is split between segments 1 and 6, and the second active dwell between segments 2 and 5. In both cases the earlier segment gets the half rounded up and the later segment the half rounded down.
- R5: Let the zero dwell be z = 4q + r, with 0 <= r < 4. Segment 0 lasts q+(r>0) cycles, segment 3 lasts q+(r>1), segment 4 lasts q+(r>2) and segment 7 lasts q. The period therefore lasts exactly a+b+z cycles.
- R6: A segment of length zero is skipped and never appears on `seg_o`.
- R7: The inputs are sampled only at the period boundary. A change in the middle of a period has no effect until the next period starts.
- R8: Sector codes 0 and 7 are treated as sector 1.
- R9: If all three dwells are zero, the period lasts one cycle and shows segment 0 of the sampled sector.
- R10: While reset is held, `gate_o` is 101 and `seg_o` is 0. The first period is sampled at the first clock edge after reset is released.
- R11: When `seg_o` steps from one segment to the next inside a period, at most one gate bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_i | input | 3 | Sector number, 1 to 6 |
| dwell_a_i | input | DW | First active dwell, in cycles |
| dwell_b_i | input | DW | Second active dwell, in cycles |
| dwell_z_i | input | DW | Effective-zero dwell, in cycles |
| gate_o | output | 3 | Leg gate bits: A in bit 2, C in bit 0 |
| seg_o | output | 3 | Index of the current segment |

## Verification
The inputs for a period are sampled at the clock edge that ends the previous period. The first segment of the new period is visible on both outputs right after that edge. Each later segment appears exactly as many edges later as the lengths of the segments before it. The bench keeps this timing by sampling on the falling edge. It counts cycle by cycle from the edge that sampled the inputs, and works out the expected segment and gate bits for each cycle from the dwell splits. The inputs for the following period are applied during the first cycle of the current one, so every period also checks that a change in mid-period is ignored until the boundary.

// File: rtl/azs_pkg.sv
package azs_pkg;

    localparam int NSEG = 8;

    typedef logic [2:0] gate_t;

    // Which of the four sector states a segment emits.
    typedef enum logic [1:0] {
        ROLE_ZERO_A = 2'd0,
        ROLE_ACT_1  = 2'd1,
        ROLE_ACT_2  = 2'd2,
        ROLE_ZERO_B = 2'd3
    } role_e;

    // The pattern is mirrored: 0 1 2 3 | 4 5 6 7 maps to ZA A1 A2 ZB | ZB A2 A1 ZA.
    function automatic role_e seg_role(input logic [2:0] seg);
        logic [1:0] half;
        half = seg[2] ? ~seg[1:0] : seg[1:0];
        return role_e'(half);
    endfunction

    // Bit 2 is leg A, bit 0 is leg C.
    function automatic gate_t sector_state(input logic [2:0] sec, input role_e r);
        gate_t v;
        v = 3'b101;
        unique case (sec)
            3'd2: case (r)
                ROLE_ZERO_A: v = 3'b011;
                ROLE_ACT_1:  v = 3'b010;
                ROLE_ACT_2:  v = 3'b110;
                default:     v = 3'b100;
            endcase
            3'd3: case (r)
                ROLE_ZERO_A: v = 3'b110;
                ROLE_ACT_1:  v = 3'b010;
                ROLE_ACT_2:  v = 3'b011;
                default:     v = 3'b001;
            endcase
            3'd4: case (r)
                ROLE_ZERO_A: v = 3'b101;
                ROLE_ACT_1:  v = 3'b001;
                ROLE_ACT_2:  v = 3'b011;
                default:     v = 3'b010;
            endcase
            3'd5: case (r)
                ROLE_ZERO_A: v = 3'b011;
                ROLE_ACT_1:  v = 3'b001;
                ROLE_ACT_2:  v = 3'b101;
                default:     v = 3'b100;
            endcase
            3'd6: case (r)
                ROLE_ZERO_A: v = 3'b110;
                ROLE_ACT_1:  v = 3'b100;
                ROLE_ACT_2:  v = 3'b101;
                default:     v = 3'b001;
            endcase
            default: case (r)
                ROLE_ZERO_A: v = 3'b101;
                ROLE_ACT_1:  v = 3'b100;
                ROLE_ACT_2:  v = 3'b110;
                default:     v = 3'b010;
            endcase
        endcase
        return v;
    endfunction

endpackage

// File: rtl/azs_dwell_split.sv
module azs_dwell_split #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]         dwell_a,
    input  logic [DW-1:0]         dwell_b,
    input  logic [DW-1:0]         dwell_z,
    output logic [7:0][DW-1:0]    seg_len
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] a_lo, a_hi, b_lo, b_hi, z_q;
    logic [1:0]    z_r;
    logic          all_zero;

    always_comb begin
        a_lo     = dwell_a >> 1;
        a_hi     = a_lo + (dwell_a[0] ? ONE : '0);
        b_lo     = dwell_b >> 1;
        b_hi     = b_lo + (dwell_b[0] ? ONE : '0);
        z_q      = dwell_z >> 2;
        z_r      = dwell_z[1:0];
        all_zero = (dwell_a == '0) && (dwell_b == '0) && (dwell_z == '0);

        seg_len[0] = all_zero ? ONE : z_q + ((z_r != 2'd0) ? ONE : '0);
        seg_len[1] = a_hi;
        seg_len[2] = b_hi;
        seg_len[3] = z_q + ((z_r > 2'd1) ? ONE : '0);
        seg_len[4] = z_q + ((z_r > 2'd2) ? ONE : '0);
        seg_len[5] = b_lo;
        seg_len[6] = a_lo;
        seg_len[7] = z_q;
    end
endmodule

// File: rtl/azs_seg_pick.sv
module azs_seg_pick #(
    parameter int DW   = 8,
    parameter int NSEG = 8
) (
    input  logic [NSEG-1:0][DW-1:0] seg_len,
    input  logic [3:0]              from_idx,
    output logic                    hit,
    output logic [2:0]              idx
);
    // Lowest non-empty segment at or above from_idx.
    always_comb begin
        hit = 1'b0;
        idx = 3'd0;
        for (int k = NSEG - 1; k >= 0; k--) begin
            if (seg_len[k] != '0 && 4'(k) >= from_idx) begin
                hit = 1'b1;
                idx = 3'(k);
            end
        end
    end
endmodule

// File: rtl/azs_vec_lut.sv
module azs_vec_lut
    import azs_pkg::*;
(
    input  logic [2:0] sector,
    input  logic [2:0] seg,
    output gate_t      gate
);
    always_comb gate = sector_state(sector, seg_role(seg));
endmodule

// File: rtl/azs_sequencer.sv
module azs_sequencer
    import azs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sector_i,
    input  logic [DW-1:0] dwell_a_i,
    input  logic [DW-1:0] dwell_b_i,
    input  logic [DW-1:0] dwell_z_i,
    output logic [2:0]    gate_o,
    output logic [2:0]    seg_o
);
    typedef struct packed {
        logic                   live;
        logic [2:0]             sec;
        logic [2:0]             seg;
        logic [DW-1:0]          left;
        logic [NSEG-1:0][DW-1:0] len;
        gate_t                  gate;
    } st_t;

    st_t q, d;

    logic [2:0]              sec_in;
    logic [NSEG-1:0][DW-1:0] new_len;
    logic                    new_hit, cur_hit;
    logic [2:0]              new_idx, cur_idx;
    gate_t                   new_gate, cur_gate;
    logic [3:0]              cur_from;
    logic                    seg_end;
    logic                    wrap_w;
    logic [DW-1:0]           left_w;

    assign sec_in   = (sector_i >= 3'd1 && sector_i <= 3'd6) ? sector_i : 3'd1;
    assign cur_from = {1'b0, q.seg} + 4'd1;

    azs_dwell_split #(.DW(DW)) u_split (
        .dwell_a (dwell_a_i),
        .dwell_b (dwell_b_i),
        .dwell_z (dwell_z_i),
        .seg_len (new_len)
    );

    azs_seg_pick #(.DW(DW), .NSEG(NSEG)) u_pick_new (
        .seg_len  (new_len),
        .from_idx (4'd0),
        .hit      (new_hit),
        .idx      (new_idx)
    );

    azs_seg_pick #(.DW(DW), .NSEG(NSEG)) u_pick_cur (
        .seg_len  (q.len),
        .from_idx (cur_from),
        .hit      (cur_hit),
        .idx      (cur_idx)
    );

    azs_vec_lut u_lut_new (.sector(sec_in), .seg(new_idx), .gate(new_gate));
    azs_vec_lut u_lut_cur (.sector(q.sec),  .seg(cur_idx), .gate(cur_gate));

    always_comb begin
        d       = q;
        seg_end = (q.left <= DW'(1));
        wrap_w  = !q.live || (seg_end && !cur_hit);
        if (wrap_w) begin
            d.live = 1'b1;
            d.sec  = sec_in;
            d.len  = new_len;
            d.seg  = new_idx;
            d.left = new_hit ? new_len[new_idx] : DW'(1);
            d.gate = new_gate;
        end else if (seg_end) begin
            d.seg  = cur_idx;
            d.left = q.len[cur_idx];
            d.gate = cur_gate;
        end else begin
            d.left = q.left - DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.live <= 1'b0;
            q.sec  <= 3'd1;
            q.seg  <= 3'd0;
            q.left <= '0;
            q.len  <= '0;
            q.gate <= 3'b101;
        end else begin
            q <= d;
        end
    end

    assign gate_o = q.gate;
    assign seg_o  = q.seg;
    assign left_w = q.left;
endmodule

// File: rtl/azs_sequencer_chk.sv
module azs_sequencer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    gate,
    input logic [2:0]    seg,
    input logic          wrap,
    input logic [DW-1:0] left
);
    // R1
    a_r1_no_rail_state: assert property (@(posedge clk) disable iff (!rst_n)
        gate != 3'b000 && gate != 3'b111);

    // R3
    a_r3_seg_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(seg) && !$past(wrap)) |-> (seg > $past(seg)));

    // R5
    a_r5_seg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (left > DW'(1) && !wrap) |=> ($stable(seg) && $stable(gate)));

    // R11
    a_r11_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == 3'($past(seg) + 3'd1) && !$past(wrap))
            |-> ($countones(gate ^ $past(gate)) <= 1));
endmodule

bind azs_sequencer azs_sequencer_chk #(.DW(DW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate_o),
    .seg   (seg_o),
    .wrap  (wrap_w),
    .left  (left_w)
);

// File: tb/azs_sequencer_tb.sv
module azs_sequencer_tb;
    localparam int DW = 8;
    localparam int NCOMBO = 9;
    localparam int NPER = 8 * NCOMBO;
    localparam int CA[NCOMBO] = '{3, 5, 1, 0, 2, 0, 0, 4, 7};
    localparam int CB[NCOMBO] = '{4, 2, 0, 3, 2, 0, 0, 1, 6};
    localparam int CZ[NCOMBO] = '{8, 9, 10, 11, 0, 1, 0, 2, 3};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [2:0]    sector;
    logic [DW-1:0] da, db, dz;
    logic [2:0]    gate, seg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    azs_sequencer #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sector_i(sector),
        .dwell_a_i(da), .dwell_b_i(db), .dwell_z_i(dz),
        .gate_o(gate), .seg_o(seg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int p);
        int pp;
        pp = p % NPER;
        sector = 3'(pp / NCOMBO);
        da = DW'(CA[pp % NCOMBO]);
        db = DW'(CB[pp % NCOMBO]);
        dz = DW'(CZ[pp % NCOMBO]);
    endtask

    // R2 R8: expected gate bits for a sector code and segment index
    function automatic int exp_gate(input int s, input int sg);
        int ss, role;
        int st[4];
        ss = (s < 1 || s > 6) ? 1 : s;
        role = (sg < 4) ? sg : 7 - sg;
        case (ss)
            1: st = '{5, 4, 6, 2};
            2: st = '{3, 2, 6, 4};
            3: st = '{6, 2, 3, 1};
            4: st = '{5, 1, 3, 2};
            5: st = '{3, 1, 5, 4};
            default: st = '{6, 4, 5, 1};
        endcase
        return st[role];
    endfunction

    // R4 R5 R9: expected segment lengths
    function automatic int seg_len(input int a, input int b, input int z, input int k);
        int q, r;
        q = z / 4;
        r = z % 4;
        case (k)
            0: return (a + b + z == 0) ? 1 : q + (r > 0 ? 1 : 0);
            1: return (a + 1) / 2;
            2: return (b + 1) / 2;
            3: return q + (r > 1 ? 1 : 0);
            4: return q + (r > 2 ? 1 : 0);
            5: return b / 2;
            6: return a / 2;
            default: return q;
        endcase
    endfunction

    task automatic run_period(input int p);
        int a, b, z, s, tot, es, acc, prev_seg;
        int prev_gate;
        int len[8];
        s = p / NCOMBO;
        a = CA[p % NCOMBO];
        b = CB[p % NCOMBO];
        z = CZ[p % NCOMBO];
        tot = 0;
        for (int k = 0; k < 8; k++) begin
            len[k] = seg_len(a, b, z, k);
            tot += len[k];
        end
        prev_seg = -1;
        prev_gate = 0;
        for (int i = 0; i < tot; i++) begin
            @(negedge clk);
            // R7: the next period's inputs arrive mid-period
            if (i == 0) drive(p + 1);
            es = 0;
            acc = 0;
            for (int k = 0; k < 8; k++) begin
                if (i >= acc && i < acc + len[k]) es = k;
                acc += len[k];
            end
            chk(int'(seg) == es, "R3 R4 R5 R6 R7 seg", int'(seg), es);
            chk(int'(gate) == exp_gate(s, es), "R2 R8 R9 gate", int'(gate), exp_gate(s, es));
            chk($countones(gate) == 1 || $countones(gate) == 2, "R1 popcount",
                $countones(gate), 1);
            if (i > 0 && int'(seg) == prev_seg + 1)
                chk($countones(3'(gate) ^ 3'(prev_gate)) <= 1, "R11 step",
                    $countones(3'(gate) ^ 3'(prev_gate)), 1);
            prev_seg = int'(seg);
            prev_gate = int'(gate);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0);
        repeat (3) @(negedge clk);
        chk(gate == 3'b101, "R10 reset gate", int'(gate), 5);
        chk(seg == 3'd0, "R10 reset seg", int'(seg), 0);
        rst_n = 1'b1;
        for (int p = 0; p < NPER; p++) run_period(p);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule